// File: doc/BRIEF.md
# Display Scanline Timing Counter

This block generates the line and frame timing for a video display. It counts system clock cycles into scanlines and scanlines into frames. Each line lasts a fixed number of clocks. The first group of lines is the visible drawing period, and the remaining lines form vertical blank. A frame of the default configuration is 228 lines of 1232 clocks: 160 visible lines and 68 blank lines, 280896 clocks in total.

The current line number is held in a read-only register at I/O offset 0x006. Two single-clock pulses can drive an interrupt controller directly. One marks the line counter reaching the first blank line. The other marks the counter wrapping back to line 0 at the end of a frame.

Top module: `scan_timing`

## Requirements
- R1: While `rst` is high, the cycle and line counters are held at 0, `vblank_start_o` and `frame_wrap_o` stay low, and `rd_data_o` reads 0.
- R2: After reset is released, the line number is floor(k / CYCLES_PER_LINE) mod TOTAL_LINES once k rising clock edges have passed. It advances by exactly one every CYCLES_PER_LINE clocks.
- R3: When the line number is TOTAL_LINES-1, the next line boundary takes it to 0. It never holds a value of TOTAL_LINES or higher.
- R4: `frame_wrap_o` is high for exactly one clock: the clock in which the line number has just become 0 after a wrap. It is not asserted after reset.
- R5: `vblank_start_o` is high for exactly one clock: the clock in which the line number has just become VISIBLE_LINES (default 160).
- R6: A read with `rd_en_i` high and `rd_addr_i` equal to LINE_ADDR (default 0x006) returns, one clock later on `rd_data_o`, the line number as it was at the read edge. The line number sits in the low bits and all upper bits are zero.
- R7: A read to any other address, or a clock with `rd_en_i` low, gives `rd_data_o` = 0 in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read offset |
| rd_data_o | output | DATA_W | Registered read data |
| vblank_start_o | output | 1 | One-clock pulse on entry to vertical blank |
| frame_wrap_o | output | 1 | One-clock pulse when the line number wraps to 0 |

## Verification
The frame wrap and the vertical blank entry are the hardest cases to reach: each happens only once per frame, and at default sizes a frame runs for hundreds of thousands of clocks. The bench therefore builds the block with a small line length and line count. It sweeps several complete frames clock by clock, predicting every pulse and every read value arithmetically from the number of edges since reset. A reset asserted in the middle of a frame, with a read pending, confirms that the counters restart cleanly.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  typedef struct packed {
    logic vblank;
    logic wrap;
  } scan_evt_t;

  localparam int DEF_CYCLES_PER_LINE = 1232;
  localparam int DEF_VISIBLE_LINES   = 160;
  localparam int DEF_TOTAL_LINES     = 228;
endpackage

// File: rtl/scan_cycle_ctr.sv
module scan_cycle_ctr #(
  parameter int CYCLES_PER_LINE = 1232,
  localparam int CYC_W = (CYCLES_PER_LINE > 1) ? $clog2(CYCLES_PER_LINE) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic line_end_o
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(CYCLES_PER_LINE - 1);

  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst)                cyc_q <= '0;
    else if (cyc_q == LAST) cyc_q <= '0;
    else                    cyc_q <= cyc_q + 1'b1;
  end

  assign line_end_o = (cyc_q == LAST);

  // R2
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_q <= LAST);
endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr
  import scan_timing_pkg::*;
#(
  parameter int VISIBLE_LINES = 160,
  parameter int TOTAL_LINES   = 228,
  localparam int LINE_W = (TOTAL_LINES > 1) ? $clog2(TOTAL_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end_i,
  output logic [LINE_W-1:0] line_o,
  output scan_evt_t         evt_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
  localparam logic [LINE_W-1:0] VB_LINE   = LINE_W'(VISIBLE_LINES);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_nx;
  scan_evt_t         evt_q;

  always_comb begin
    if (line_q == LAST_LINE) line_nx = '0;
    else                     line_nx = line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      evt_q  <= '0;
    end else begin
      evt_q <= '0;
      if (line_end_i) begin
        line_q       <= line_nx;
        evt_q.wrap   <= (line_q == LAST_LINE);
        evt_q.vblank <= (line_nx == VB_LINE);
      end
    end
  end

  assign line_o = line_q;
  assign evt_o  = evt_q;

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    line_q <= LAST_LINE);

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q != $past(line_q)) |-> $past(line_end_i));

  // R4
  wrap_line_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q.wrap |-> (line_q == '0));

  // R5
  vblank_line_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q.vblank |-> (line_q == VB_LINE));

  // R4
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q.wrap |=> !evt_q.wrap);
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int LINE_W    = 8,
  parameter int LINE_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(LINE_ADDR);

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst)                                 data_q <= '0;
    else if (rd_en_i && (rd_addr_i == HIT))  data_q <= DATA_W'(line_i);
    else                                     data_q <= '0;
  end

  assign rd_data_o = data_q;

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_i && rd_addr_i == HIT) |=> (rd_data_o == '0));

  // R6
  hit_value_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == HIT) |=> (rd_data_o == DATA_W'($past(line_i))));
endmodule

// File: rtl/scan_timing.sv
module scan_timing
  import scan_timing_pkg::*;
#(
  parameter int CYCLES_PER_LINE = DEF_CYCLES_PER_LINE,
  parameter int VISIBLE_LINES   = DEF_VISIBLE_LINES,
  parameter int TOTAL_LINES     = DEF_TOTAL_LINES,
  parameter int ADDR_W          = 12,
  parameter int DATA_W          = 16,
  parameter int LINE_ADDR       = 6,
  localparam int LINE_W = (TOTAL_LINES > 1) ? $clog2(TOTAL_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              vblank_start_o,
  output logic              frame_wrap_o
);
  logic              line_end;
  logic [LINE_W-1:0] line;
  scan_evt_t         evt;

  scan_cycle_ctr #(.CYCLES_PER_LINE(CYCLES_PER_LINE)) u_cyc (
    .clk(clk), .rst(rst), .line_end_o(line_end)
  );

  scan_line_ctr #(.VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES)) u_line (
    .clk(clk), .rst(rst), .line_end_i(line_end), .line_o(line), .evt_o(evt)
  );

  scan_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W),
                  .LINE_ADDR(LINE_ADDR)) u_reg (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .line_i(line), .rd_data_o(rd_data_o)
  );

  assign vblank_start_o = evt.vblank;
  assign frame_wrap_o   = evt.wrap;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!vblank_start_o && !frame_wrap_o && rd_data_o == '0));
endmodule

// File: tb/tb_scan_timing.sv
`timescale 1ns/1ps
module tb_scan_timing;
  localparam int C  = 7;
  localparam int V  = 5;
  localparam int T  = 9;
  localparam int F  = C * T;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int LA = 6;

  logic clk = 0;
  logic rst;
  logic rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic vb, fw;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_timing #(.CYCLES_PER_LINE(C), .VISIBLE_LINES(V), .TOTAL_LINES(T),
                .ADDR_W(AW), .DATA_W(DW), .LINE_ADDR(LA)) dut (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .vblank_start_o(vb), .frame_wrap_o(fw)
  );

  function automatic int line_of(int k);
    return (k / C) % T;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sweep(int edges);
    bit last_hit;
    last_hit = 0;
    for (int n = 1; n <= edges; n++) begin
      last_hit = rd_en && (rd_addr == AW'(LA));
      @(posedge clk);
      @(negedge clk);
      // R5: vblank pulse when line just became V
      check("R5", int'(vb), (n % F == C * V) ? 1 : 0);
      // R4: frame wrap pulse when line just returned to 0
      check("R4", int'(fw), (n % F == 0) ? 1 : 0);
      if (last_hit)
        check("R6", int'(rd_data), line_of(n - 1));   // R2 R3 via line sequence
      else
        check("R7", int'(rd_data), 0);
      rd_en   = (n % 5 != 3);
      rd_addr = (n % 7 == 4) ? AW'(LA + 2) : AW'(LA);
    end
  endtask

  initial begin
    rst = 1; rd_en = 1; rd_addr = AW'(LA);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(vb), 0);
    check("R1", int'(fw), 0);
    check("R1", int'(rd_data), 0);
    rst = 0;
    sweep(3 * F + 4);
    // mid-frame reset with a read pending
    rst = 1; rd_en = 1; rd_addr = AW'(LA);
    @(posedge clk); @(negedge clk);
    check("R1", int'(rd_data), 0);
    check("R1", int'(vb) + int'(fw), 0);
    @(posedge clk); @(negedge clk);
    check("R1", int'(rd_data), 0);
    rst = 0;
    sweep(F + 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule